// File: doc/BRIEF.md
# Class-Separated Message Queues Between First- and Second-Level Cache Controllers

This block holds the messages that pass between a first-level (L1) and a second-level (L2) cache controller on a snooping bus. Each direction carries two kinds of traffic, and each kind has its own 4-entry FIFO. Toward L2 go processor requests, plus snoop responses that leave on the bus. Toward L1 go processor responses and snoop requests.

The consumer of a message never pops it unless the reply it must produce is sure of space. The L2 controller takes a processor request only while the processor-response queue has room. It writes its reply in the same cycle. The L1 controller takes a snoop request only while the snoop-response storage has room. It writes its snoop response in the same cycle. Processor responses generate no further traffic, so they are offered with no condition. Snoop responses leave whenever the bus is granted. With these rules the queues cannot wait on each other in a cycle, and the block cannot deadlock.

Producers supply only a payload of address and ID. The block adds the 2-bit class field. With `SHARED_UPLINK` set, processor requests and snoop responses share one upward FIFO. This gives the three-queue arrangement, and the head of that FIFO is routed by its class.

Top module: `l1l2_msg_queues`

## Requirements
- R1: After reset, every `*_valid_o` output is low, and `l1_preq_ready_o` and `l2_snp_ready_o` are high.
- R2: Each queue holds `DEPTH` (4) messages in arrival order. An input's ready output is low while its queue is full.
- R3: `l2_preq_valid_o` is high only when the processor-response queue has a free entry. The processor-response queue never holds more than `DEPTH` messages.
- R4: When L2 accepts a processor request, `l2_prsp_msg_i` is enqueued in that same cycle. The response is offered at `l1_prsp_*` from the next cycle on.
- R5: `l1_prsp_valid_o` is high whenever the processor-response queue is non-empty, whatever the state of the other queues.
- R6: `l1_snp_valid_o` is high only when the snoop-response storage has a free entry. When L1 accepts a snoop request, `l1_snp_rsp_msg_i` is enqueued in that same cycle.
- R7: A snoop response leaves only in a cycle with `bus_grant_i` high. Without a grant, `bus_rsp_valid_o` stays high and `bus_rsp_msg_o` stays unchanged.
- R8: Messages are {class[1:0], address[ADDR_W-1:0], id[ID_W-1:0]}, with the class in the top two bits. The block stamps the class per queue: 0 for a processor request, 1 for a snoop response, 2 for a processor response, 3 for a snoop request.
- R9: An offered processor request at `l2_preq_*` stays valid and unchanged until L2 accepts it.
- R10: With `SHARED_UPLINK`=1, processor requests and snoop responses share one `DEPTH`-entry FIFO. A class-0 head goes to `l2_preq_*` and a class-1 head goes to `bus_rsp_*`. A head that is not accepted blocks the entries behind it.
- R11: With `SHARED_UPLINK`=1, in a cycle where L1 accepts a snoop request, `l1_preq_ready_o` is low. Only the snoop response is written in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l1_preq_valid_i | input | 1 | L1 offers a processor request |
| l1_preq_ready_o | output | 1 | Processor request accepted |
| l1_preq_msg_i | input | ADDR_W+ID_W | Processor request payload |
| l2_preq_valid_o | output | 1 | Processor request offered to L2 |
| l2_preq_ready_i | input | 1 | L2 takes the processor request |
| l2_preq_msg_o | output | ADDR_W+ID_W+2 | Processor request message |
| l2_prsp_msg_i | input | ADDR_W+ID_W | Reply payload, written when L2 takes a request |
| l1_prsp_valid_o | output | 1 | Processor response offered to L1 |
| l1_prsp_ready_i | input | 1 | L1 takes the processor response |
| l1_prsp_msg_o | output | ADDR_W+ID_W+2 | Processor response message |
| l2_snp_valid_i | input | 1 | L2 offers a snoop request |
| l2_snp_ready_o | output | 1 | Snoop request accepted |
| l2_snp_msg_i | input | ADDR_W+ID_W | Snoop request payload |
| l1_snp_valid_o | output | 1 | Snoop request offered to L1 |
| l1_snp_ready_i | input | 1 | L1 takes the snoop request |
| l1_snp_msg_o | output | ADDR_W+ID_W+2 | Snoop request message |
| l1_snp_rsp_msg_i | input | ADDR_W+ID_W | Snoop response payload, written when L1 takes a snoop |
| bus_grant_i | input | 1 | Bus granted; the snoop-response head leaves |
| bus_rsp_valid_o | output | 1 | A snoop response is waiting for the bus |
| bus_rsp_msg_o | output | ADDR_W+ID_W+2 | Snoop response message |

## Verification
The properties assume that the consumer supplies its reply payload in the same cycle as it raises ready. They also assume that `bus_grant_i` is meant to pop a snoop response only while one is offered. The properties check occupancy by counting handshakes at the ports, and nothing else bounds those counts. The stimulus drives every input half a cycle away from the clock edge. It drives a reply payload whenever it raises a consumer ready. It holds grant and ready high long enough to fill, block and release each queue in turn, so that every full and empty boundary is reached. A second instance, built with the shared upward FIFO, is driven separately to exercise class routing and the single-write rule.

// File: rtl/msg_pkg.sv
package msg_pkg;
  localparam int unsigned CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_PREQ    = 2'd0,
    CLS_SNP_RSP = 2'd1,
    CLS_PRSP    = 2'd2,
    CLS_SNP_REQ = 2'd3
  } msg_cls_e;
endpackage

// File: rtl/msg_fifo.sv
module msg_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end
endmodule

// File: rtl/l1l2_uplink.sv
// Storage for L1-to-L2 traffic: two class queues, or one shared queue routed by head class.
module l1l2_uplink #(
  parameter int unsigned W      = 8,
  parameter int unsigned DEPTH  = 4,
  parameter bit          SHARED = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         preq_push_i,
  input  logic [W-1:0] preq_data_i,
  output logic         preq_full_o,
  input  logic         rsp_push_i,
  input  logic [W-1:0] rsp_data_i,
  output logic         rsp_full_o,
  output logic         preq_avail_o,
  output logic [W-1:0] preq_head_o,
  input  logic         preq_pop_i,
  output logic         rsp_avail_o,
  output logic [W-1:0] rsp_head_o,
  input  logic         rsp_pop_i
);
  import msg_pkg::*;

  if (SHARED) begin : g_shared
    logic         full, empty, head_is_preq;
    logic [W-1:0] head, wdata;

    // snoop response wins the single write port
    assign wdata = rsp_push_i ? rsp_data_i : preq_data_i;

    msg_fifo #(.W(W), .DEPTH(DEPTH)) u_q (
      .clk_i, .rst_ni,
      .push_i (preq_push_i || rsp_push_i),
      .data_i (wdata),
      .pop_i  (preq_pop_i || rsp_pop_i),
      .data_o (head),
      .full_o (full),
      .empty_o(empty)
    );

    assign head_is_preq = (head[W-1 -: CLS_W] == CLS_PREQ);
    assign preq_full_o  = full;
    assign rsp_full_o   = full;
    assign preq_avail_o = !empty && head_is_preq;
    assign rsp_avail_o  = !empty && !head_is_preq;
    assign preq_head_o  = head;
    assign rsp_head_o   = head;
  end else begin : g_split
    logic preq_empty, rsp_empty;

    msg_fifo #(.W(W), .DEPTH(DEPTH)) u_preq_q (
      .clk_i, .rst_ni,
      .push_i (preq_push_i),
      .data_i (preq_data_i),
      .pop_i  (preq_pop_i),
      .data_o (preq_head_o),
      .full_o (preq_full_o),
      .empty_o(preq_empty)
    );

    msg_fifo #(.W(W), .DEPTH(DEPTH)) u_rsp_q (
      .clk_i, .rst_ni,
      .push_i (rsp_push_i),
      .data_i (rsp_data_i),
      .pop_i  (rsp_pop_i),
      .data_o (rsp_head_o),
      .full_o (rsp_full_o),
      .empty_o(rsp_empty)
    );

    assign preq_avail_o = !preq_empty;
    assign rsp_avail_o  = !rsp_empty;
  end
endmodule

// File: rtl/l1l2_msg_queues.sv
module l1l2_msg_queues #(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned ID_W          = 4,
  parameter int unsigned DEPTH         = 4,
  parameter bit          SHARED_UPLINK = 1'b0,
  localparam int unsigned PL_W  = ADDR_W + ID_W,
  localparam int unsigned MSG_W = PL_W + msg_pkg::CLS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l1_preq_valid_i,
  output logic             l1_preq_ready_o,
  input  logic [PL_W-1:0]  l1_preq_msg_i,
  output logic             l2_preq_valid_o,
  input  logic             l2_preq_ready_i,
  output logic [MSG_W-1:0] l2_preq_msg_o,
  input  logic [PL_W-1:0]  l2_prsp_msg_i,
  output logic             l1_prsp_valid_o,
  input  logic             l1_prsp_ready_i,
  output logic [MSG_W-1:0] l1_prsp_msg_o,
  input  logic             l2_snp_valid_i,
  output logic             l2_snp_ready_o,
  input  logic [PL_W-1:0]  l2_snp_msg_i,
  output logic             l1_snp_valid_o,
  input  logic             l1_snp_ready_i,
  output logic [MSG_W-1:0] l1_snp_msg_o,
  input  logic [PL_W-1:0]  l1_snp_rsp_msg_i,
  input  logic             bus_grant_i,
  output logic             bus_rsp_valid_o,
  output logic [MSG_W-1:0] bus_rsp_msg_o
);
  import msg_pkg::*;

  logic preq_full, rsp_full, preq_avail, rsp_avail;
  logic prsp_full, prsp_empty, snp_full, snp_empty;
  logic preq_push, l2_fire, snp_fire, bus_pop, prsp_pop, snp_push;

  // L1 side: a snoop is handed over only if its response has a slot
  assign l1_snp_valid_o  = !snp_empty && !rsp_full;
  assign snp_fire        = l1_snp_valid_o && l1_snp_ready_i;
  assign l1_preq_ready_o = !preq_full && !(SHARED_UPLINK && snp_fire);
  assign preq_push       = l1_preq_valid_i && l1_preq_ready_o;

  // L2 side: a request is handed over only if its reply has a slot
  assign l2_preq_valid_o = preq_avail && !prsp_full;
  assign l2_fire         = l2_preq_valid_o && l2_preq_ready_i;

  assign bus_rsp_valid_o = rsp_avail;
  assign bus_pop         = rsp_avail && bus_grant_i;

  assign l1_prsp_valid_o = !prsp_empty;
  assign prsp_pop        = l1_prsp_valid_o && l1_prsp_ready_i;

  assign l2_snp_ready_o  = !snp_full;
  assign snp_push        = l2_snp_valid_i && !snp_full;

  l1l2_uplink #(.W(MSG_W), .DEPTH(DEPTH), .SHARED(SHARED_UPLINK)) u_uplink (
    .clk_i, .rst_ni,
    .preq_push_i (preq_push),
    .preq_data_i ({CLS_PREQ, l1_preq_msg_i}),
    .preq_full_o (preq_full),
    .rsp_push_i  (snp_fire),
    .rsp_data_i  ({CLS_SNP_RSP, l1_snp_rsp_msg_i}),
    .rsp_full_o  (rsp_full),
    .preq_avail_o(preq_avail),
    .preq_head_o (l2_preq_msg_o),
    .preq_pop_i  (l2_fire),
    .rsp_avail_o (rsp_avail),
    .rsp_head_o  (bus_rsp_msg_o),
    .rsp_pop_i   (bus_pop)
  );

  msg_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_prsp_q (
    .clk_i, .rst_ni,
    .push_i (l2_fire),
    .data_i ({CLS_PRSP, l2_prsp_msg_i}),
    .pop_i  (prsp_pop),
    .data_o (l1_prsp_msg_o),
    .full_o (prsp_full),
    .empty_o(prsp_empty)
  );

  msg_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_snp_q (
    .clk_i, .rst_ni,
    .push_i (snp_push),
    .data_i ({CLS_SNP_REQ, l2_snp_msg_i}),
    .pop_i  (snp_fire),
    .data_o (l1_snp_msg_o),
    .full_o (snp_full),
    .empty_o(snp_empty)
  );
endmodule

// File: rtl/l1l2_msg_queues_chk.sv
module l1l2_msg_queues_chk #(
  parameter int unsigned DEPTH         = 4,
  parameter int unsigned MSG_W         = 38,
  parameter bit          SHARED_UPLINK = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             l1_preq_valid_i,
  input logic             l1_preq_ready_o,
  input logic             l2_preq_valid_o,
  input logic             l2_preq_ready_i,
  input logic [MSG_W-1:0] l2_preq_msg_o,
  input logic             l1_prsp_valid_o,
  input logic             l1_prsp_ready_i,
  input logic [MSG_W-1:0] l1_prsp_msg_o,
  input logic             l1_snp_valid_o,
  input logic             l1_snp_ready_i,
  input logic [MSG_W-1:0] l1_snp_msg_o,
  input logic             bus_grant_i,
  input logic             bus_rsp_valid_o,
  input logic [MSG_W-1:0] bus_rsp_msg_o
);
  logic preq_fire, l2_fire, prsp_fire, snp_fire, bus_pop;
  int   prsp_cnt, up_cnt;

  assign preq_fire = l1_preq_valid_i && l1_preq_ready_o;
  assign l2_fire   = l2_preq_valid_o && l2_preq_ready_i;
  assign prsp_fire = l1_prsp_valid_o && l1_prsp_ready_i;
  assign snp_fire  = l1_snp_valid_o && l1_snp_ready_i;
  assign bus_pop   = bus_rsp_valid_o && bus_grant_i;

  // occupancy rebuilt from port handshakes only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prsp_cnt <= 0;
      up_cnt   <= 0;
    end else begin
      prsp_cnt <= prsp_cnt + int'(l2_fire) - int'(prsp_fire);
      up_cnt   <= up_cnt + int'(snp_fire) - int'(bus_pop)
                + (SHARED_UPLINK ? int'(preq_fire) - int'(l2_fire) : 0);
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !l2_preq_valid_o && !l1_prsp_valid_o && !l1_snp_valid_o && !bus_rsp_valid_o);

  p_prsp_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prsp_cnt <= int'(DEPTH));

  p_reply_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_fire |=> l1_prsp_valid_o);

  p_prsp_offered_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prsp_cnt != 0 |-> l1_prsp_valid_o);

  p_snp_rsp_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_cnt <= int'(DEPTH));

  p_snp_rsp_queued_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!SHARED_UPLINK && snp_fire) |=> bus_rsp_valid_o);

  p_grant_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rsp_valid_o && !bus_grant_i) |=> bus_rsp_valid_o && $stable(bus_rsp_msg_o));

  p_cls_preq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_preq_valid_o |-> l2_preq_msg_o[MSG_W-1 -: 2] == 2'd0);

  p_cls_prsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_prsp_valid_o |-> l1_prsp_msg_o[MSG_W-1 -: 2] == 2'd2);

  p_cls_snp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_snp_valid_o |-> l1_snp_msg_o[MSG_W-1 -: 2] == 2'd3);

  p_cls_bus_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rsp_valid_o |-> bus_rsp_msg_o[MSG_W-1 -: 2] == 2'd1);

  p_preq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l2_preq_valid_o && !l2_preq_ready_i) |=> l2_preq_valid_o && $stable(l2_preq_msg_o));

  p_single_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SHARED_UPLINK && snp_fire) |-> !l1_preq_ready_o);
endmodule

bind l1l2_msg_queues l1l2_msg_queues_chk #(
  .DEPTH(DEPTH), .MSG_W(MSG_W), .SHARED_UPLINK(SHARED_UPLINK)
) u_chk (
  .clk_i, .rst_ni, .l1_preq_valid_i, .l1_preq_ready_o,
  .l2_preq_valid_o, .l2_preq_ready_i, .l2_preq_msg_o,
  .l1_prsp_valid_o, .l1_prsp_ready_i, .l1_prsp_msg_o,
  .l1_snp_valid_o, .l1_snp_ready_i, .l1_snp_msg_o,
  .bus_grant_i, .bus_rsp_valid_o, .bus_rsp_msg_o
);

// File: tb/sim_l1l2_msg_queues.sv
module sim_l1l2_msg_queues;
  localparam int unsigned PL_W  = 36;
  localparam int unsigned MSG_W = 38;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // split instance
  logic req_v = 0, req_rdy, pr_v, l2_rdy = 0, py_v, py_rdy = 0;
  logic l2snp_v = 0, l2snp_rdy, snp_v, snp_rdy = 0, grant = 0, bus_v;
  logic [PL_W-1:0]  req_p = '0, l2rsp_p = '0, l2snp_p = '0, snprsp_p = '0;
  logic [MSG_W-1:0] pr_m, py_m, snp_m, bus_m;

  // shared-uplink instance
  logic m_req_v = 0, m_req_rdy, m_pr_v, m_l2_rdy = 0, m_py_v, m_py_rdy = 0;
  logic m_l2snp_v = 0, m_l2snp_rdy, m_snp_v, m_snp_rdy = 0, m_grant = 0, m_bus_v;
  logic [PL_W-1:0]  m_req_p = '0, m_l2rsp_p = '0, m_l2snp_p = '0, m_snprsp_p = '0;
  logic [MSG_W-1:0] m_pr_m, m_py_m, m_snp_m, m_bus_m;

  l1l2_msg_queues u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .l1_preq_valid_i(req_v), .l1_preq_ready_o(req_rdy), .l1_preq_msg_i(req_p),
    .l2_preq_valid_o(pr_v), .l2_preq_ready_i(l2_rdy), .l2_preq_msg_o(pr_m),
    .l2_prsp_msg_i(l2rsp_p),
    .l1_prsp_valid_o(py_v), .l1_prsp_ready_i(py_rdy), .l1_prsp_msg_o(py_m),
    .l2_snp_valid_i(l2snp_v), .l2_snp_ready_o(l2snp_rdy), .l2_snp_msg_i(l2snp_p),
    .l1_snp_valid_o(snp_v), .l1_snp_ready_i(snp_rdy), .l1_snp_msg_o(snp_m),
    .l1_snp_rsp_msg_i(snprsp_p),
    .bus_grant_i(grant), .bus_rsp_valid_o(bus_v), .bus_rsp_msg_o(bus_m)
  );

  l1l2_msg_queues #(.SHARED_UPLINK(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n),
    .l1_preq_valid_i(m_req_v), .l1_preq_ready_o(m_req_rdy), .l1_preq_msg_i(m_req_p),
    .l2_preq_valid_o(m_pr_v), .l2_preq_ready_i(m_l2_rdy), .l2_preq_msg_o(m_pr_m),
    .l2_prsp_msg_i(m_l2rsp_p),
    .l1_prsp_valid_o(m_py_v), .l1_prsp_ready_i(m_py_rdy), .l1_prsp_msg_o(m_py_m),
    .l2_snp_valid_i(m_l2snp_v), .l2_snp_ready_o(m_l2snp_rdy), .l2_snp_msg_i(m_l2snp_p),
    .l1_snp_valid_o(m_snp_v), .l1_snp_ready_i(m_snp_rdy), .l1_snp_msg_o(m_snp_m),
    .l1_snp_rsp_msg_i(m_snprsp_p),
    .bus_grant_i(m_grant), .bus_rsp_valid_o(m_bus_v), .bus_rsp_msg_o(m_bus_m)
  );

  function automatic logic [PL_W-1:0] pl(input int a);
    return {32'(a), 4'(a)};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_msg(input string req, input logic [MSG_W-1:0] m, input int cls, input int a);
    chk(req, 64'(m[MSG_W-1 -: 2]), 64'(cls));
    chk(req, 64'(m[35:4]), 64'(a));
  endtask

  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic t_reset();
    chk("R1 valid", {pr_v, py_v, snp_v, bus_v, m_pr_v, m_py_v, m_snp_v, m_bus_v}, 0);
    chk("R1 ready", {req_rdy, l2snp_rdy, m_req_rdy, m_l2snp_rdy}, 4'hf);
  endtask

  task automatic t_preq_flow();
    for (int i = 0; i < 3; i++) begin
      req_v = 1; req_p = pl('h100 + i); nxt();
    end
    req_v = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R2 order", pr_v, 1);
      chk_msg("R8 preq class", pr_m, 0, 'h100 + i);
      l2_rdy = 1; l2rsp_p = pl('h200 + i); nxt();
    end
    l2_rdy = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R4 reply", py_v, 1);
      chk_msg("R8 prsp class", py_m, 2, 'h200 + i);
      py_rdy = 1; nxt();
    end
    py_rdy = 0;
    chk("R4 drained", {py_v, pr_v}, 0);
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 4; i++) begin
      req_v = 1; req_p = pl('h180 + i); nxt();
    end
    req_v = 0;
    chk("R2 full", req_rdy, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R2 head", 64'(pr_m[35:4]), 'h180 + i);
      l2_rdy = 1; l2rsp_p = pl('h280 + i); nxt();
    end
    l2_rdy = 0;
    req_v = 1; req_p = pl('h1f0); nxt(); req_v = 0;
    chk("R3 gated", pr_v, 0);
    chk("R5 offered", py_v, 1);
    py_rdy = 1; nxt(); py_rdy = 0;
    chk("R3 released", pr_v, 1);
    chk_msg("R3 head", pr_m, 0, 'h1f0);
    l2_rdy = 1; l2rsp_p = pl('h284); nxt(); l2_rdy = 0;
    for (int i = 0; i < 4; i++) begin
      chk_msg("R5 drain", py_m, 2, 'h281 + i);
      py_rdy = 1; nxt();
    end
    py_rdy = 0;
    chk("R5 empty", py_v, 0);
  endtask

  task automatic t_snoop();
    for (int i = 0; i < 4; i++) begin
      l2snp_v = 1; l2snp_p = pl('h300 + i); nxt();
    end
    l2snp_v = 0;
    chk("R2 snp full", l2snp_rdy, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R6 offered", snp_v, 1);
      chk_msg("R8 snp class", snp_m, 3, 'h300 + i);
      snp_rdy = 1; snprsp_p = pl('h400 + i); nxt();
    end
    snp_rdy = 0;
    l2snp_v = 1; l2snp_p = pl('h304); nxt(); l2snp_v = 0;
    chk("R6 gated", snp_v, 0);
    chk("R7 waiting", bus_v, 1);
    chk_msg("R8 bus class", bus_m, 1, 'h400);
    nxt(); nxt();
    chk("R7 no grant", bus_v, 1);
    chk_msg("R7 held", bus_m, 1, 'h400);
    for (int i = 0; i < 4; i++) begin
      chk_msg("R7 order", bus_m, 1, 'h400 + i);
      if (i == 1) chk("R6 released", snp_v, 1);
      grant = 1; nxt();
    end
    grant = 0;
    chk("R7 empty", bus_v, 0);
    chk_msg("R6 head", snp_m, 3, 'h304);
    snp_rdy = 1; snprsp_p = pl('h404); nxt(); snp_rdy = 0;
    chk_msg("R6 same cycle", bus_m, 1, 'h404);
    grant = 1; nxt(); grant = 0;
    chk("R7 drained", {bus_v, snp_v}, 0);
  endtask

  task automatic t_hold();
    req_v = 1; req_p = pl('h500); nxt(); req_v = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R9 valid", pr_v, 1);
      chk_msg("R9 stable", pr_m, 0, 'h500);
      nxt();
    end
    l2_rdy = 1; l2rsp_p = pl('h510); nxt(); l2_rdy = 0;
    chk("R9 taken", pr_v, 0);
    chk_msg("R4 reply", py_m, 2, 'h510);
    py_rdy = 1; nxt(); py_rdy = 0;
  endtask

  task automatic t_shared();
    m_l2snp_v = 1; m_l2snp_p = pl('h600); nxt(); m_l2snp_v = 0;
    chk("R10 snp offered", m_snp_v, 1);
    m_snp_rdy = 1; m_snprsp_p = pl('h610);
    m_req_v = 1; m_req_p = pl('h620); #1;
    chk("R11 write blocked", m_req_rdy, 0);
    nxt(); m_snp_rdy = 0; #1;
    chk("R11 write after", m_req_rdy, 1);
    nxt(); m_req_v = 0;
    chk_msg("R10 bus head", m_bus_m, 1, 'h610);
    chk("R10 bus valid", m_bus_v, 1);
    chk("R10 preq blocked", m_pr_v, 0);
    m_l2_rdy = 1; m_l2rsp_p = pl('h630); nxt();
    chk("R10 still blocked", m_pr_v, 0);
    m_grant = 1; nxt(); m_grant = 0;
    chk("R10 bus gone", m_bus_v, 0);
    chk("R10 preq valid", m_pr_v, 1);
    chk_msg("R10 preq head", m_pr_m, 0, 'h620);
    nxt(); m_l2_rdy = 0;
    chk_msg("R4 shared reply", m_py_m, 2, 'h630);
    m_py_rdy = 1; nxt(); m_py_rdy = 0;
    m_l2snp_v = 1; m_l2snp_p = pl('h700); nxt(); m_l2snp_v = 0;
    for (int i = 0; i < 4; i++) begin
      m_req_v = 1; m_req_p = pl('h710 + i); nxt();
    end
    m_req_v = 0;
    chk("R10 shared full", m_req_rdy, 0);
    chk("R10 snp gated", m_snp_v, 0);
    m_l2_rdy = 1; m_py_rdy = 1;
    for (int i = 0; i < 4; i++) begin
      chk_msg("R10 order", m_pr_m, 0, 'h710 + i);
      nxt();
    end
    m_l2_rdy = 0; nxt(); m_py_rdy = 0;
    chk("R10 snp released", m_snp_v, 1);
    m_snp_rdy = 1; m_snprsp_p = pl('h720); nxt(); m_snp_rdy = 0;
    chk_msg("R10 rsp routed", m_bus_m, 1, 'h720);
    m_grant = 1; nxt(); m_grant = 0;
    chk("R10 empty", {m_bus_v, m_pr_v, m_py_v}, 0);
  endtask

  initial begin
    #5 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_preq_flow();
    t_backpressure();
    t_snoop();
    t_hold();
    t_shared();
    summary();
    $finish;
  end
endmodule